// File: doc/BRIEF.md
# Counter-Based Loop Pipeline Controller

This block sequences a pipelined loop datapath through three phases: a prologue that fills the input queue and the datapath, a steady state that issues one iteration every `PERIOD` cycles, and an epilogue that drains the results still in flight. The iteration count arrives on a port with the start request, so one build serves any loop length up to the width of that port.

The phases are not written as an enumerated state table. Four limit counters track them instead: prologue cycles, position within a steady period, steady iterations, and epilogue cycles. Each counter counts up to its limit and then flags that it has reached it. A small phase register moves between the phases on those flags. A combinational decoder turns the phase and the period position into five datapath strobes: shift-in, load A, halve, load B and store. The outputs depend only on registered state.

With an iteration count n and `DEPTH` iterations in flight at the end, the steady state runs max(n - DEPTH, 0) iterations and the epilogue drains min(n, DEPTH) results. This gives exactly n store strobes in total.

Top module: `loop_pipe_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, all five strobes and `done_o` are low.
- R2: A run starts with a prologue of `LAT_CYC + FILL_CYC` cycles, beginning the cycle after start is taken. In each prologue cycle `shift_o` is high and every other strobe is low.
- R3: The steady state then runs K = n - DEPTH iterations when n > DEPTH, each `PERIOD` cycles long. At position 0 of a period, `shift_o` and `load_a_o` are high. At positions other than 0, `halve_o` is high. At position `PERIOD-1`, `load_b_o` and `store_o` are high.
- R4: The epilogue lasts (E-1)*PERIOD+1 cycles, where E = min(n, DEPTH). At positions p = cycle index mod PERIOD, `load_b_o` and `store_o` are high when p is 0 and `halve_o` is high otherwise. `shift_o` and `load_a_o` stay low.
- R5: When n <= DEPTH, the prologue is followed directly by the epilogue, with no steady cycles.
- R6: A run of n iterations produces exactly n cycles with `store_o` high.
- R7: `done_o` is high for exactly one cycle, the cycle after the last epilogue cycle, and is low for the rest of the run. The controller is idle on the following cycle.
- R8: `start_i` is ignored unless the controller is idle. A start during a run neither restarts nor extends it.
- R9: A start with `iter_n_i` equal to zero is ignored, and the controller stays idle.
- R10: Asserting `rst_ni` low during a run forces all outputs low at once and returns the controller to idle.
- R11: The iteration count is sampled only when start is taken. Later changes on `iter_n_i` do not alter the running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured in idle only |
| iter_n_i | input | NW | Loop iteration count n |
| shift_o | output | 1 | Shift the input queue and take a new sample |
| load_a_o | output | 1 | Load the first pipeline register |
| halve_o | output | 1 | Shift the result register right by one bit |
| load_b_o | output | 1 | Load the second pipeline register |
| store_o | output | 1 | Store one result |
| done_o | output | 1 | One-cycle pulse after the epilogue |

## Verification
The bench builds the controller with `FILL_CYC=2`, `LAT_CYC=1`, `PERIOD=3`, `DEPTH=2` and an 8-bit count. With a three-position period, the head, middle and last positions of both the steady and epilogue decode are all distinct, and an error in the position logic shows up cycle by cycle. A drain depth of two makes n=1 and n=2 reach the path with no steady phase, and n=3 gives a single steady iteration. Random counts up to 20 cover the iteration counter over several wraps of the period counter.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRO    = 3'd1,
    PH_STEADY = 3'd2,
    PH_EPI    = 3'd3,
    PH_FIN    = 3'd4
  } phase_e;

  typedef struct packed {
    logic shift;
    logic load_a;
    logic halve;
    logic load_b;
    logic store;
  } strobe_t;

endpackage

// File: rtl/lim_cnt.sv
module lim_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (en_i && cnt_q != limit_i)  cnt_q <= cnt_q + W'(1);
  end

  assign last_o = (cnt_q == limit_i);

endmodule

// File: rtl/strobe_dec.sv
module strobe_dec
  import loop_ctrl_pkg::*;
(
  input  phase_e  phase_i,
  input  logic    head_i,
  input  logic    tail_i,
  output strobe_t strb_o
);

  always_comb begin
    strb_o = '0;
    unique case (phase_i)
      PH_PRO: strb_o.shift = 1'b1;
      PH_STEADY: begin
        strb_o.shift  = head_i;
        strb_o.load_a = head_i;
        strb_o.halve  = !head_i;
        strb_o.load_b = tail_i;
        strb_o.store  = tail_i;
      end
      PH_EPI: begin
        strb_o.halve  = !head_i;
        strb_o.load_b = head_i;
        strb_o.store  = head_i;
      end
      default: strb_o = '0;
    endcase
  end

endmodule

// File: rtl/loop_pipe_ctrl.sv
module loop_pipe_ctrl
  import loop_ctrl_pkg::*;
#(
  parameter int NW       = 16,
  parameter int FILL_CYC = 2,
  parameter int LAT_CYC  = 1,
  parameter int PERIOD   = 2,
  parameter int DEPTH    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] iter_n_i,
  output logic          shift_o,
  output logic          load_a_o,
  output logic          halve_o,
  output logic          load_b_o,
  output logic          store_o,
  output logic          done_o
);

  localparam int PRO_LEN = LAT_CYC + FILL_CYC;
  localparam int PRW     = $clog2(PRO_LEN + 1);
  localparam int PW      = $clog2(PERIOD);
  localparam int EW      = $clog2(DEPTH * PERIOD + 1);

  phase_e phase_q, phase_d;
  logic   accept, phase_chg;
  logic   pro_last, slot_last, iter_last, epi_last;
  logic   head_q, steady_q;
  logic [NW-1:0] iter_lim_q;
  logic [EW-1:0] epi_lim_q;
  logic [31:0]   n_ext, e_ext;
  strobe_t strb;

  assign accept    = (phase_q == PH_IDLE) && start_i && (iter_n_i != '0);
  assign phase_chg = (phase_d != phase_q);

  // limits derived once per run from the sampled count
  assign n_ext = 32'(iter_n_i);
  assign e_ext = (n_ext > 32'(DEPTH)) ? 32'(DEPTH) : n_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steady_q   <= 1'b0;
      iter_lim_q <= '0;
      epi_lim_q  <= '0;
    end else if (accept) begin
      steady_q   <= n_ext > 32'(DEPTH);
      iter_lim_q <= NW'(n_ext - 32'(DEPTH) - 32'd1);
      epi_lim_q  <= EW'((e_ext - 32'd1) * 32'(PERIOD));
    end
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_PRO;
      PH_PRO:    if (pro_last) phase_d = steady_q ? PH_STEADY : PH_EPI;
      PH_STEADY: if (slot_last && iter_last) phase_d = PH_EPI;
      PH_EPI:    if (epi_last) phase_d = PH_FIN;
      PH_FIN:    phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      head_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      head_q  <= phase_chg || slot_last;  // slot position returns to 0
    end
  end

  lim_cnt #(.W(PRW)) u_pro_cnt (
    .clk_i, .rst_ni,
    .clr_i  (phase_chg),
    .en_i   (phase_q == PH_PRO),
    .limit_i(PRW'(PRO_LEN - 1)),
    .last_o (pro_last)
  );

  lim_cnt #(.W(PW)) u_slot_cnt (
    .clk_i, .rst_ni,
    .clr_i  (phase_chg || slot_last),
    .en_i   (phase_q == PH_STEADY || phase_q == PH_EPI),
    .limit_i(PW'(PERIOD - 1)),
    .last_o (slot_last)
  );

  lim_cnt #(.W(NW)) u_iter_cnt (
    .clk_i, .rst_ni,
    .clr_i  (phase_chg),
    .en_i   (phase_q == PH_STEADY && slot_last),
    .limit_i(iter_lim_q),
    .last_o (iter_last)
  );

  lim_cnt #(.W(EW)) u_epi_cnt (
    .clk_i, .rst_ni,
    .clr_i  (phase_chg),
    .en_i   (phase_q == PH_EPI),
    .limit_i(epi_lim_q),
    .last_o (epi_last)
  );

  strobe_dec u_dec (
    .phase_i(phase_q),
    .head_i (head_q),
    .tail_i (slot_last),
    .strb_o (strb)
  );

  assign shift_o  = strb.shift;
  assign load_a_o = strb.load_a;
  assign halve_o  = strb.halve;
  assign load_b_o = strb.load_b;
  assign store_o  = strb.store;
  assign done_o   = (phase_q == PH_FIN);

endmodule

// File: rtl/loop_pipe_ctrl_chk.sv
module loop_pipe_ctrl_chk
  import loop_ctrl_pkg::*;
#(
  parameter int NW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [NW-1:0] iter_n_i,
  input logic          shift_o,
  input logic          load_a_o,
  input logic          halve_o,
  input logic          load_b_o,
  input logic          store_o,
  input logic          done_o,
  input phase_e        phase_q
);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_IDLE |-> !(shift_o || load_a_o || halve_o || load_b_o || store_o || done_o));

  assert_prologue_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_PRO |-> shift_o && !store_o && !halve_o && !load_a_o);

  assert_store_no_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> !shift_o && !load_a_o && load_b_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(store_o) && !store_o);

  assert_busy_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STEADY || phase_q == PH_EPI) |=> phase_q != PH_PRO && phase_q != PH_IDLE);

  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i && iter_n_i == '0) |=> phase_q == PH_IDLE);

endmodule

bind loop_pipe_ctrl loop_pipe_ctrl_chk #(.NW(NW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .iter_n_i(iter_n_i),
  .shift_o (shift_o),
  .load_a_o(load_a_o),
  .halve_o (halve_o),
  .load_b_o(load_b_o),
  .store_o (store_o),
  .done_o  (done_o),
  .phase_q (phase_q)
);

// File: tb/tb_loop_pipe_ctrl.sv
module tb_loop_pipe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NW  = 8;
  localparam int FIL = 2;
  localparam int LAT = 1;
  localparam int C   = 3;
  localparam int D   = 2;
  localparam int P   = FIL + LAT;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NW-1:0] iter_n_i = '0;
  logic shift_o, load_a_o, halve_o, load_b_o, store_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_pipe_ctrl #(.NW(NW), .FILL_CYC(FIL), .LAT_CYC(LAT), .PERIOD(C), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni, .start_i, .iter_n_i,
    .shift_o, .load_a_o, .halve_o, .load_b_o, .store_o, .done_o
  );

  function automatic logic [5:0] outs();
    return {shift_o, load_a_o, halve_o, load_b_o, store_o, done_o};
  endfunction

  // expected {shift,load_a,halve,load_b,store,done} at cycle t after start
  function automatic logic [5:0] exp_vec(int n, int t);
    int k, e, tail, u, v, p;
    k = (n > D) ? n - D : 0;
    e = (n > D) ? D : n;
    tail = (e - 1) * C + 1;
    if (t < P) return 6'b100000;
    u = t - P;
    if (u < k * C) begin
      p = u % C;
      return {p == 0, p == 0, p != 0, p == C-1, p == C-1, 1'b0};
    end
    v = u - k * C;
    if (v < tail) begin
      p = v % C;
      return {1'b0, 1'b0, p != 0, p == 0, p == 0, 1'b0};
    end
    if (v == tail) return 6'b000001;
    return 6'b000000;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // poke: mid-run start with a different count (R8, R11)
  task automatic run_loop(int n, bit poke);
    int k, e, total, stores, dones;
    string tag;
    k = (n > D) ? n - D : 0;
    e = (n > D) ? D : n;
    total = P + k * C + (e - 1) * C + 2;
    stores = 0;
    dones = 0;
    @(negedge clk);
    start_i = 1'b1;
    iter_n_i = NW'(n);
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= total; t++) begin
      if (t < P) tag = "R2";
      else if (t - P < k * C) tag = "R3";
      else if (t - P - k * C < (e - 1) * C + 1) tag = (k == 0) ? "R5" : "R4";
      else tag = "R7";
      if (poke && t > 2) tag = {tag, "/R8/R11"};
      chk(outs() == exp_vec(n, t), tag, int'(outs()), int'(exp_vec(n, t)));
      stores += int'(store_o);
      dones  += int'(done_o);
      if (poke && t == 2) begin
        start_i = 1'b1;
        iter_n_i = NW'(n + 5);
      end else if (poke && t == 3) begin
        start_i = 1'b0;
      end else if (poke && t == P + 4) begin
        start_i = 1'b1;
      end else if (poke && t == P + 5) begin
        start_i = 1'b0;
      end
      if (t < total) @(negedge clk);
    end
    chk(stores == n, "R6 store count", stores, n);
    chk(dones == 1, "R7 done count", dones, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    #(CLK_PERIOD * 2 + 1);
    chk(outs() == 6'b0, "R1 in reset", int'(outs()), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(outs() == 6'b0, "R1 after reset", int'(outs()), 0);

    run_loop(1, 1'b0);   // R5 shortest run
    run_loop(2, 1'b0);   // R5 at drain depth
    run_loop(3, 1'b0);   // R3 single steady iteration
    run_loop(7, 1'b1);   // R8 R11 start pokes mid-run

    // R9: zero count is ignored
    @(negedge clk);
    start_i = 1'b1;
    iter_n_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(outs() == 6'b0, "R9 zero count", int'(outs()), 0);
      @(negedge clk);
    end

    // R10: reset in the middle of a run
    start_i = 1'b1;
    iter_n_i = NW'(10);
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(outs() == 6'b0, "R10 async reset", int'(outs()), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(outs() == 6'b0, "R10 idle after reset", int'(outs()), 0);
    end
    run_loop(4, 1'b0);   // R10 recovers cleanly

    for (int i = 0; i < 15; i++) begin
      run_loop(int'($urandom_range(1, 20)), (i % 4) == 0);  // R3 R4 R6 random
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule